// File: doc/BRIEF.md
# Widening Lane Shift Unit

This unit takes a 128-bit vector operand and uses one of its two 64-bit halves. It cuts that half into lanes of 8, 16 or 32 bits and doubles the width of every lane. Each lane is then shifted left by its own original width. The product is a 128-bit vector in which every output lane holds the source lane in its upper half and zeros in its lower half.

A 2-bit size code chooses the lane width, and one of its four encodings is reserved. A half-select bit chooses which 64 bits of the operand are used. The unit sits in a vector execute stage. It accepts one operation per cycle when the input strobe is high and gives the result one cycle later. It flags the reserved encoding instead of producing a result.

Top module: `wlsh_unit`

## Requirements
- R1: With size code 00, the half is treated as eight 8-bit lanes. Source lane e (half bits 8e+7:8e) lands in result bits 16e+15:16e+8.
- R2: With size code 01, the half is treated as four 16-bit lanes. Source lane e (half bits 16e+15:16e) lands in result bits 32e+31:32e+16.
- R3: With size code 10, the half is treated as two 32-bit lanes. Source lane e (half bits 32e+31:32e) lands in result bits 64e+63:64e+32.
- R4: When upper_i is 0, the lanes come from opnd_i[63:0]. When upper_i is 1, they come from opnd_i[127:64], and the other half has no effect on the result.
- R5: The lower half of every output lane is zero. The upper half equals the source lane bits exactly, so a set sign bit never spreads into other bits.
- R6: A valid operation with size code 11 gives undef_o=1, valid_o=0 and result_o=0 in the following cycle.
- R7: The result and valid_o appear exactly one cycle after the operation is accepted. A cycle with valid_i=0 gives valid_o=0, undef_o=0 and result_o=0 in the next cycle.
- R8: While rst_ni is low, valid_o, undef_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Lane width code (00=8, 01=16, 10=32, 11=reserved) |
| upper_i | input | 1 | Half select (0=bits 63:0, 1=bits 127:64) |
| opnd_i | input | 128 | Vector operand |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| undef_o | output | 1 | Reserved size code seen |
| result_o | output | 128 | Widened, shifted vector |

## Verification
Two things can fall on the same output cycle boundary: a reserved-code report and a normal widened result. A reserved code may arrive right after a valid operation, or a valid operation right after a reserved code. Either way the result register must drop the previous lane data in the same edge that it raises or clears the flag. The bench sends back-to-back streams that alternate between reserved codes, all three lane widths and both halves, with no idle gaps. The scoreboard then judges every cycle on the flag, the strobe and the full 128-bit result together.

// File: rtl/wlsh_pkg.sv
package wlsh_pkg;
  localparam int unsigned VEC_W  = 128;
  localparam int unsigned HALF_W = VEC_W / 2;
  localparam int unsigned N_SZ   = 3;

  typedef enum logic [1:0] {
    SZ_B   = 2'b00,
    SZ_H   = 2'b01,
    SZ_S   = 2'b10,
    SZ_RSV = 2'b11
  } lane_sz_e;
endpackage

// File: rtl/wlsh_half_sel.sv
module wlsh_half_sel #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned HALF_W = VEC_W / 2
) (
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              upper_i,
  output logic [HALF_W-1:0] half_o
);
  assign half_o = upper_i ? vec_i[VEC_W-1:HALF_W] : vec_i[HALF_W-1:0];
endmodule

// File: rtl/wlsh_lane_widen.sv
module wlsh_lane_widen #(
  parameter int unsigned HALF_W = 64,
  parameter int unsigned ES     = 8
) (
  input  logic [HALF_W-1:0]   half_i,
  output logic [2*HALF_W-1:0] wide_o
);
  localparam int unsigned LANES = HALF_W / ES;
  localparam int unsigned OW    = 2 * ES;

  // sign-extend, shift by ES, truncate to OW: sign bits fall off the top
  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [OW-1:0] sext;
    logic [OW-1:0] shl;
    assign sext = {{ES{half_i[e*ES+ES-1]}}, half_i[e*ES +: ES]};
    assign shl  = sext << ES;
    assign wide_o[e*OW +: OW] = shl;
  end
endmodule

// File: rtl/wlsh_unit.sv
module wlsh_unit
  import wlsh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       size_i,
  input  logic             upper_i,
  input  logic [VEC_W-1:0] opnd_i,
  output logic             valid_o,
  output logic             undef_o,
  output logic [VEC_W-1:0] result_o
);
  logic [HALF_W-1:0] half;
  logic [VEC_W-1:0]  wide [N_SZ];
  logic [VEC_W-1:0]  wide_sel;
  logic              rsv;

  wlsh_half_sel #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_half (
    .vec_i   (opnd_i),
    .upper_i (upper_i),
    .half_o  (half)
  );

  for (genvar k = 0; k < N_SZ; k++) begin : g_sz
    wlsh_lane_widen #(.HALF_W(HALF_W), .ES(8 << k)) u_widen (
      .half_i (half),
      .wide_o (wide[k])
    );
  end

  assign rsv = (lane_sz_e'(size_i) == SZ_RSV);

  always_comb begin
    unique case (lane_sz_e'(size_i))
      SZ_B:    wide_sel = wide[0];
      SZ_H:    wide_sel = wide[1];
      SZ_S:    wide_sel = wide[2];
      default: wide_sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      undef_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= valid_i & ~rsv;
      undef_o  <= valid_i & rsv;
      result_o <= (valid_i & ~rsv) ? wide_sel : '0;
    end
  end
endmodule

// File: rtl/wlsh_unit_chk.sv
module wlsh_unit_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [1:0]   size_i,
  input logic         upper_i,
  input logic [127:0] opnd_i,
  input logic         valid_o,
  input logic         undef_o,
  input logic [127:0] result_o
);
  AST_RSV_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b11) |=> (undef_o && !valid_o && result_o == '0)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !undef_o && result_o == '0)); // R7

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i != 2'b11) |=> (valid_o && !undef_o)); // R7

  AST_S_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b10 && upper_i) |=>
      result_o == {$past(opnd_i[127:96]), 32'h0, $past(opnd_i[95:64]), 32'h0}); // R3

  AST_H_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b01 && !upper_i) |=>
      result_o == {$past(opnd_i[63:48]), 16'h0, $past(opnd_i[47:32]), 16'h0,
                   $past(opnd_i[31:16]), 16'h0, $past(opnd_i[15:0]), 16'h0}); // R2

  AST_B_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b00) |=>
      (result_o[7:0] == 8'h0 && result_o[23:16] == 8'h0 && result_o[119:112] == 8'h0)); // R5

  always_comb begin
    if (rst_ni) AST_EXCL: assert (!(valid_o && undef_o)); // R6
  end
endmodule

bind wlsh_unit wlsh_unit_chk u_chk (.*);

// File: tb/wlsh_unit_tb.sv
`timescale 1ns/1ps
module wlsh_unit_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   size_i = 2'b00;
  logic         upper_i = 1'b0;
  logic [127:0] opnd_i = '0;
  logic         valid_o, undef_o;
  logic [127:0] result_o;

  int n_chk = 0, n_fail = 0;
  bit run_on = 1'b0;

  typedef struct {
    logic         v;
    logic         u;
    logic [127:0] r;
    string        tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;

  wlsh_unit u_dut (.*);

  function automatic logic [127:0] model(logic [127:0] op, logic [1:0] sz, logic up);
    logic [63:0]  h;
    logic [127:0] r;
    int es;
    h = up ? op[127:64] : op[63:0];
    r = '0;
    es = 8 << sz;
    for (int e = 0; e < 64 / es; e++)
      for (int b = 0; b < es; b++)
        r[e*2*es + es + b] = h[e*es + b];
    return r;
  endfunction

  function automatic string tag_of(logic v, logic [1:0] sz, logic up);
    if (!v) return "R7";
    if (sz == 2'b11) return "R6";
    if (up) return "R4";
    return (sz == 2'b00) ? "R1" : (sz == 2'b01) ? "R2" : "R3";
  endfunction

  task automatic check(string tag, logic v, logic u, logic [127:0] r);
    n_chk++;
    if (valid_o !== v || undef_o !== u || result_o !== r) begin
      n_fail++;
      $display("FAIL %s: got v=%b u=%b r=%h exp v=%b u=%b r=%h",
               tag, valid_o, undef_o, result_o, v, u, r);
    end
  endtask

  // driver: one item per cycle, expected pushed into scoreboard
  task automatic drive(logic v, logic [1:0] sz, logic up, logic [127:0] op);
    exp_t x;
    @(negedge clk_i);
    valid_i = v; size_i = sz; upper_i = up; opnd_i = op;
    x.v = v && sz != 2'b11;
    x.u = v && sz == 2'b11;
    x.r = x.v ? model(op, sz, up) : '0;
    x.tag = tag_of(v, sz, up);
    sb_q.push_back(x);
  endtask

  // monitor
  initial forever begin
    @(posedge clk_i);
    #1;
    if (run_on && sb_q.size() > 0) begin
      exp_t x;
      x = sb_q.pop_front();
      check(x.tag, x.v, x.u, x.r);
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang exp completion");
    finish_run();
  end

  initial begin
    logic [127:0] pat;
    #1;
    valid_i = 1'b1; size_i = 2'b10; opnd_i = '1;
    repeat (3) @(posedge clk_i);
    #1;
    check("R8", 1'b0, 1'b0, '0);
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    run_on = 1'b1;

    // each width, both halves, sign-set lanes (R1 R2 R3 R4 R5)
    pat = 128'hF1E2_D3C4_B5A6_9788_8091_A2B3_C4D5_E6F7;
    for (int s = 0; s < 3; s++)
      for (int u = 0; u < 2; u++)
        drive(1'b1, s[1:0], u[0], pat);
    drive(1'b1, 2'b00, 1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    drive(1'b1, 2'b01, 1'b1, {64'h8000_7FFF_FFFF_0001, 64'h0});
    drive(1'b1, 2'b10, 1'b0, {64'hDEAD_BEEF_DEAD_BEEF, 64'h8000_0000_7FFF_FFFF});
    // other half ignored: only unused half differs (R4)
    drive(1'b1, 2'b00, 1'b0, {64'h0, 64'h1122_3344_5566_7788});
    drive(1'b1, 2'b00, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h1122_3344_5566_7788});

    // reserved code interleaved back-to-back (R6 R7)
    drive(1'b1, 2'b11, 1'b0, '1);
    drive(1'b1, 2'b10, 1'b1, pat);
    drive(1'b1, 2'b11, 1'b1, pat);
    drive(1'b1, 2'b11, 1'b0, pat);
    drive(1'b1, 2'b01, 1'b0, pat);
    drive(1'b0, 2'b00, 1'b0, pat);
    drive(1'b0, 2'b11, 1'b1, '1);
    drive(1'b1, 2'b00, 1'b1, '1);

    for (int i = 0; i < 40; i++) begin
      pat = {$urandom, $urandom, $urandom, $urandom};
      drive(i % 7 != 6, 2'(i % 4), 1'(i % 3 == 1), pat);
    end
    drive(1'b0, 2'b00, 1'b0, '0);
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule